// File: doc/BRIEF.md
# Serial Readback Port with End-of-Data Interrupt

This block is the slave side of a serial read path. Bytes produced inside the chip are pushed into an outbound queue. A host then drains them over an SPI-style link made of a serial clock, an active-low select and a single data line. An active-low interrupt line, `irq_n`, tells the host that bytes are waiting. During a transfer the same line marks where the data ends: it is released on the seventh rising serial-clock edge of the final byte. The host then clocks out the last bit and deselects.

Data leaves MSB first. The data line changes after falling serial-clock edges, so the host samples it on rising edges. The serial clock and the select are brought into the system clock domain through flop synchronizers, and every action follows an edge detected there. If the host deselects before the end-of-data release, the remaining bytes of that transfer are dropped.

Top module: `spi_rdbk_port`

## Requirements
- R1: Each byte leaves MSB first. Its first bit is on `sdo` before the first rising serial-clock edge after select. Each later bit appears after a falling serial-clock edge.
- R2: Within one select period, queued bytes follow one another in push order with no idle bit between them.
- R3: When the queue holds data, `irq_n` goes low and stays low through rising edges one to six of every byte. It rises only at the seventh edge of the last byte.
- R4: At the seventh rising edge of a byte with nothing queued behind it, `irq_n` goes high. It stays high through the eighth edge and until `cs_n` goes high.
- R5: If another byte is queued at the seventh rising edge, `irq_n` stays low and the next byte follows.
- R6: If `cs_n` rises after a byte was loaded but before the release, the current byte and every queued byte are discarded. `irq_n` then reads high, and the next byte pushed is the first one sent.
- R7: While deselected, `sdo_oe` is 0 and the bit position returns to the start of a byte. A transfer cut short mid-byte is followed by a byte-aligned transfer.
- R8: The queue holds 16 bytes. `queue_full` is 1 exactly when it holds 16, and a push while full is ignored.
- R9: A byte pushed after the release keeps `irq_n` high until `cs_n` rises. `irq_n` then goes low, and the byte is kept for the next transfer.
- R10: After reset, `irq_n` is 1 and `sdo_oe` and `queue_full` are 0. Each response to a change on `sclk` or `cs_n` shows on the third rising system-clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Push strobe for the outbound queue |
| push_data | input | 8 | Byte to enqueue |
| queue_full | output | 1 | Queue holds 16 bytes |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low select from host |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | Drive enable for `sdo` (0 = high impedance) |
| irq_n | output | 1 | Active-low data-waiting / end-of-data line |

## Verification
Each pin change passes two synchronizer flops and an edge register, so `sdo`, `sdo_oe` and `irq_n` move on the third system-clock edge after the host changes `sclk` or `cs_n`. The bench drives pins just after a falling system-clock edge. It samples exactly two and then three falling edges later at select to confirm that boundary. Every other pin change is followed by six system cycles before outputs are read, so samples always land after the update and before the next host edge. A push reaches `irq_n` and `queue_full` within two cycles, and those checks wait at least that long.

// File: rtl/rdbk_pkg.sv
`timescale 1ns/1ps
package rdbk_pkg;

    // Edge events of one synchronized host pin
    typedef struct packed {
        logic rise;
        logic fall;
    } pin_evt_t;

    // Per-select transfer bookkeeping of the shifter
    typedef struct packed {
        logic cs_on;     // host has selected the port
        logic active;    // shifter holds a byte not yet fully clocked
        logic started;   // at least one byte loaded in this select period
        logic released;  // end-of-data already signalled in this period
    } xfer_flags_t;

endpackage

// File: rtl/rdbk_sync.sv
`timescale 1ns/1ps
module rdbk_sync
    import rdbk_pkg::*;
#(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pin,
    output pin_evt_t evt
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
            last  <= RST_VAL;
        end else begin
            chain <= {chain[STAGES-2:0], pin};
            last  <= chain[STAGES-1];
        end
    end

    assign evt.rise = chain[STAGES-1] & ~last;
    assign evt.fall = ~chain[STAGES-1] & last;
endmodule

// File: rtl/rdbk_fifo.sv
`timescale 1ns/1ps
module rdbk_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic              flush,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     count;
    logic              do_push, do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // R8: a push into a full queue changes nothing
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !flush) |=> (full && $stable(count)));
endmodule

// File: rtl/rdbk_shifter.sv
`timescale 1ns/1ps
module rdbk_shifter
    import rdbk_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  pin_evt_t          sclk_evt,
    input  pin_evt_t          csn_evt,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] head,
    output logic              pop,
    output logic              flush,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              irq_n
);
    localparam int            BW     = $clog2(DATA_W);
    localparam logic [BW-1:0] LAST   = BW'(DATA_W - 1);
    localparam logic [BW-1:0] PENULT = BW'(DATA_W - 2);

    logic [DATA_W-1:0] shreg, shreg_d;
    logic [BW-1:0]     bitcnt, bitcnt_d;
    xfer_flags_t       fl, fl_d;
    logic              irq_n_q, irq_n_d;
    logic              select, deselect, rise, fall, pending;

    assign select   = csn_evt.fall;
    assign deselect = csn_evt.rise;
    assign rise     = sclk_evt.rise & fl.cs_on;
    assign fall     = sclk_evt.fall & fl.cs_on;

    always_comb begin
        fl_d     = fl;
        bitcnt_d = bitcnt;
        shreg_d  = shreg;
        pop      = 1'b0;
        flush    = 1'b0;
        if (deselect) begin
            flush    = fl.started & ~fl.released;
            fl_d     = '0;
            bitcnt_d = '0;
        end else if (select) begin
            fl_d.cs_on = 1'b1;
            if (!fifo_empty) begin
                pop          = 1'b1;
                shreg_d      = head;
                fl_d.active  = 1'b1;
                fl_d.started = 1'b1;
            end
        end else if (rise) begin
            if (bitcnt == LAST) begin
                bitcnt_d    = '0;
                fl_d.active = 1'b0;
            end else begin
                bitcnt_d = bitcnt + 1'b1;
            end
            if (bitcnt == PENULT && fl.active && fifo_empty)
                fl_d.released = 1'b1;
        end else if (fall) begin
            if (bitcnt == '0 && !fl.active && !fl.released && !fifo_empty) begin
                pop          = 1'b1;
                shreg_d      = head;
                fl_d.active  = 1'b1;
                fl_d.started = 1'b1;
            end else begin
                shreg_d = {shreg[DATA_W-2:0], 1'b0};
            end
        end
    end

    assign pending = (!fifo_empty && !flush) || fl_d.active;
    assign irq_n_d = fl_d.released || !pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            bitcnt  <= '0;
            fl      <= '0;
            irq_n_q <= 1'b1;
        end else begin
            shreg   <= shreg_d;
            bitcnt  <= bitcnt_d;
            fl      <= fl_d;
            irq_n_q <= irq_n_d;
        end
    end

    assign sdo    = shreg[DATA_W-1];
    assign sdo_oe = fl.cs_on;
    assign irq_n  = irq_n_q;

    // R3: a low request holds through every edge other than the penultimate one
    p_irq_low_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!irq_n_q && fl.active && !deselect && !(rise && bitcnt == PENULT))
        |=> !irq_n_q);

    // R4: once released during a select period the request stays high next cycle
    p_irq_high_hold_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(irq_n_q) && fl.cs_on) |=> irq_n_q);

    // R7: deselect returns the bit position to zero and stops driving
    p_bit_restart_r7: assert property (@(posedge clk) disable iff (rst)
        deselect |=> (bitcnt == '0 && !sdo_oe));

    // R6: an early deselect empties the queue
    p_discard_r6: assert property (@(posedge clk) disable iff (rst)
        (deselect && fl.started && !fl.released) |=> fifo_empty);
endmodule

// File: rtl/spi_rdbk_port.sv
`timescale 1ns/1ps
module spi_rdbk_port
    import rdbk_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    output logic              queue_full,
    input  logic              sclk,
    input  logic              cs_n,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              irq_n
);
    pin_evt_t          sclk_evt, csn_evt;
    logic              fifo_empty, pop, flush;
    logic [DATA_W-1:0] head;

    rdbk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk_sync (
        .clk(clk), .rst(rst), .pin(sclk), .evt(sclk_evt)
    );

    rdbk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_csn_sync (
        .clk(clk), .rst(rst), .pin(cs_n), .evt(csn_evt)
    );

    rdbk_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_queue (
        .clk(clk), .rst(rst), .push(push_valid), .push_data(push_data),
        .pop(pop), .flush(flush), .head(head), .empty(fifo_empty),
        .full(queue_full)
    );

    rdbk_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst(rst), .sclk_evt(sclk_evt), .csn_evt(csn_evt),
        .fifo_empty(fifo_empty), .head(head), .pop(pop), .flush(flush),
        .sdo(sdo), .sdo_oe(sdo_oe), .irq_n(irq_n)
    );
endmodule

// File: tb/test_spi_rdbk_port.sv
`timescale 1ns/1ps
module test_spi_rdbk_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       push_valid = 1'b0;
    logic [7:0] push_data = '0;
    logic       queue_full;
    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic       sdo, sdo_oe, irq_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    spi_rdbk_port i_spi_rdbk_port (
        .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
        .queue_full(queue_full), .sclk(sclk), .cs_n(cs_n),
        .sdo(sdo), .sdo_oe(sdo_oe), .irq_n(irq_n)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_byte(input logic [7:0] b);
        @(negedge clk);
        push_valid = 1'b1;
        push_data  = b;
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    task automatic cs_low();
        cs_n = 1'b0;
        tick(6);
    endtask

    task automatic cs_high();
        cs_n = 1'b1;
        tick(6);
    endtask

    // one serial bit: sample data, rising edge, sample request, falling edge
    task automatic clk_bit(output logic b, output logic irq_after_rise);
        b = sdo;
        sclk = 1'b1;
        tick(6);
        irq_after_rise = irq_n;
        sclk = 1'b0;
        tick(6);
    endtask

    // iv[n-1] holds irq_n after rising edge n of the byte
    task automatic read_byte(output logic [7:0] v, output logic [7:0] iv);
        logic b, ir;
        for (int k = 7; k >= 0; k--) begin
            clk_bit(b, ir);
            v[k] = b;
            iv[7-k] = ir;
        end
    endtask

    task automatic t_reset();
        chk(irq_n === 1'b1, "R10", "irq_n after reset", int'(irq_n), 1);
        chk(sdo_oe === 1'b0, "R10", "sdo_oe after reset", int'(sdo_oe), 0);
        chk(queue_full === 1'b0, "R10", "queue_full after reset", int'(queue_full), 0);
    endtask

    task automatic t_single();
        logic [7:0] v, iv;
        push_byte(8'hA5);
        tick(2);
        chk(irq_n === 1'b0, "R3", "irq_n with data queued", int'(irq_n), 0);
        cs_n = 1'b0;
        tick(2);
        chk(sdo_oe === 1'b0, "R10", "sdo_oe two cycles after select", int'(sdo_oe), 0);
        tick(1);
        chk(sdo_oe === 1'b1, "R10", "sdo_oe three cycles after select", int'(sdo_oe), 1);
        tick(3);
        read_byte(v, iv);
        chk(v == 8'hA5, "R1", "single byte MSB first", int'(v), 8'hA5);
        chk(iv == 8'hC0, "R4", "irq_n per rising edge of final byte", int'(iv), 8'hC0);
        cs_high();
        chk(irq_n === 1'b1, "R4", "irq_n after deselect", int'(irq_n), 1);
        chk(sdo_oe === 1'b0, "R7", "sdo_oe while deselected", int'(sdo_oe), 0);
    endtask

    task automatic t_stream();
        logic [7:0] v, iv;
        logic [7:0] exp_b [3];
        exp_b[0] = 8'h3C; exp_b[1] = 8'h81; exp_b[2] = 8'hFF;
        for (int i = 0; i < 3; i++) push_byte(exp_b[i]);
        cs_low();
        for (int i = 0; i < 3; i++) begin
            read_byte(v, iv);
            chk(v == exp_b[i], "R2", "streamed byte in push order", int'(v), int'(exp_b[i]));
            if (i < 2)
                chk(iv == 8'h00, "R5", "irq_n stays low with more queued", int'(iv), 0);
            else
                chk(iv == 8'hC0, "R4", "irq_n released on last byte", int'(iv), 8'hC0);
        end
        cs_high();
    endtask

    task automatic t_early_release();
        logic [7:0] v, iv;
        logic b, ir;
        push_byte(8'hC3);
        push_byte(8'h42);
        cs_low();
        for (int i = 0; i < 3; i++) clk_bit(b, ir);
        cs_high();
        chk(irq_n === 1'b1, "R6", "irq_n after early deselect", int'(irq_n), 1);
        chk(sdo_oe === 1'b0, "R7", "sdo_oe after early deselect", int'(sdo_oe), 0);
        push_byte(8'h5A);
        tick(2);
        chk(irq_n === 1'b0, "R6", "irq_n after fresh push", int'(irq_n), 0);
        cs_low();
        read_byte(v, iv);
        chk(v == 8'h5A, "R6", "discarded bytes absent, aligned byte (R7)", int'(v), 8'h5A);
        chk(iv == 8'hC0, "R4", "irq_n pattern after discard", int'(iv), 8'hC0);
        cs_high();
    endtask

    task automatic t_full();
        logic [7:0] v, iv;
        for (int i = 0; i < 16; i++) push_byte(8'h10 + 8'(i));
        tick(1);
        chk(queue_full === 1'b1, "R8", "queue_full at 16 bytes", int'(queue_full), 1);
        push_byte(8'hEE);
        tick(1);
        chk(queue_full === 1'b1, "R8", "queue_full after extra push", int'(queue_full), 1);
        cs_low();
        for (int i = 0; i < 16; i++) begin
            read_byte(v, iv);
            chk(v == 8'h10 + 8'(i), "R8", "queued byte", int'(v), int'(8'h10 + 8'(i)));
            if (i == 15)
                chk(iv == 8'hC0, "R8", "release on 16th byte, extra push dropped", int'(iv), 8'hC0);
        end
        cs_high();
        chk(irq_n === 1'b1, "R8", "irq_n after draining full queue", int'(irq_n), 1);
        chk(queue_full === 1'b0, "R8", "queue_full after drain", int'(queue_full), 0);
    endtask

    task automatic t_late_push();
        logic [7:0] v, iv;
        logic b, ir;
        push_byte(8'h99);
        cs_low();
        for (int i = 0; i < 7; i++) clk_bit(b, ir);
        chk(ir === 1'b1, "R4", "irq_n after seventh edge", int'(ir), 1);
        push_byte(8'h77);
        tick(3);
        chk(irq_n === 1'b1, "R9", "irq_n after push past release", int'(irq_n), 1);
        clk_bit(b, ir);
        chk(ir === 1'b1, "R9", "irq_n at eighth edge", int'(ir), 1);
        cs_high();
        chk(irq_n === 1'b0, "R9", "irq_n reasserted after deselect", int'(irq_n), 0);
        cs_low();
        read_byte(v, iv);
        chk(v == 8'h77, "R9", "late byte kept", int'(v), 8'h77);
        cs_high();
    endtask

    initial begin
        tick(4);
        rst = 1'b0;
        tick(2);
        t_reset();
        t_single();
        t_stream();
        t_early_release();
        t_full();
        t_late_push();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule